// File: doc/BRIEF.md
# Pseudo-Random Challenge-Response Watchdog

This block supervises a monitored processor by posing a series of 8-bit questions and checking the answers. Each question comes from an 8-bit linear feedback shift register, so the sequence looks random to the software being watched. The processor must compute an answer from the question and its position in a four-step round. It must return that answer through a strobed data input, inside a cycle window set by configuration. A plain toggle or refresh cannot satisfy it.

Every early, late, missing or wrong answer raises an error count. A run of four correct answers lowers that count by one, and it never goes below zero. When the count reaches a configured limit, a sticky reset request is raised and questioning stops. Dropping the enable input clears the block. Raising it again reloads the register from the seed input.

Top module: `qa_watchdog`

## Requirements
- R1: While rstN is low, and after its release with enable low, challengeValid, wdReset, errCount and stepIdx are all zero.
- R2: At the first clock edge that sees enable high in the idle state, the register loads seedIn, or 8'hA5 if seedIn is zero. From the next cycle challenge shows that value, challengeValid is 1 and stepIdx is 0.
- R3: After each step outcome (answered or missed), the challenge becomes {c[6:0], c[7]^c[5]^c[4]^c[3]} for the previous challenge c. This is the polynomial x^8+x^6+x^5+x^4+1, and stepIdx increments modulo 4.
- R4: The correct answer at stepIdx k is rotl(c ^ K[k], k), rotated left by k bits, with K = {8'h3C, 8'h5A, 8'h96, 8'hE1} for k = 0..3.
- R5: Let d be the number of whole cycles between the challenge appearing and the edge that samples respStrobe (d = 0 at the first edge). An answer counts only when winOpen <= d <= winClose. An earlier strobe is an error, even if the value is correct, and still advances the step.
- R6: If no strobe has come by the edge at d = winClose, that edge records a miss: the error count rises and the step advances.
- R7: A strobed answer with the wrong value is an error and advances the step.
- R8: Every fourth consecutive correct answer lowers errCount by one, with a floor of zero. Any error restarts that run of four.
- R9: The error that brings errCount to errLimit or above sets wdReset. wdReset holds while enable stays high, challengeValid is 0 while wdReset is 1, and strobes then change nothing.
- R10: enable low clears errCount, stepIdx and wdReset at the next edge and drops challengeValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the watchdog; low clears it |
| seedIn | input | 8 | Register seed, taken when enabled |
| winOpen | input | WIN_W | First accepted elapsed-cycle count |
| winClose | input | WIN_W | Last accepted elapsed-cycle count |
| errLimit | input | ERR_W | Error count that raises the reset request |
| respData | input | 8 | Answer value |
| respStrobe | input | 1 | Answer present this cycle |
| challenge | output | 8 | Current question |
| challengeValid | output | 1 | Question is live and awaits an answer |
| stepIdx | output | 2 | Position inside the four-step round |
| errCount | output | ERR_W | Error accumulator |
| wdReset | output | 1 | Sticky reset request |

## Verification
Every outcome lands at the single edge that samples the strobe, or at the edge where d reaches winClose for a miss. The new challenge, stepIdx, errCount and wdReset all become visible together in the cycle after that edge, and the load after enable appears one cycle after enable is seen. The bench drives the strobe for exactly one cycle, d falling edges after the challenge appears, and reads every result at the next falling edge. It waits winClose+1 cycles for a miss, so each sample sits one full register stage after its cause.

// File: rtl/qa_wd_pkg.sv
package qa_wd_pkg;

  localparam logic [7:0] ZERO_SEED_FILL = 8'hA5;

  typedef struct packed {
    logic clr;
    logic load;
    logic advance;
    logic good;
    logic bad;
  } qaCtrl_t;

  function automatic logic [7:0] stepKey(input logic [1:0] k);
    case (k)
      2'd0:    return 8'h3C;
      2'd1:    return 8'h5A;
      2'd2:    return 8'h96;
      default: return 8'hE1;
    endcase
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input logic [1:0] k);
    logic [15:0] dbl;
    dbl = {v, v} << k;
    return dbl[15:8];
  endfunction

  function automatic logic [7:0] lfsrStep(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

endpackage

// File: rtl/qa_wd_datapath.sv
module qa_wd_datapath
  import qa_wd_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  qaCtrl_t          ctrl,
  input  logic [7:0]       seedIn,
  input  logic [ERR_W-1:0] errLimit,
  input  logic [7:0]       respData,
  output logic             respMatch,
  output logic [7:0]       challenge,
  output logic [1:0]       stepIdx,
  output logic [ERR_W-1:0] errCount,
  output logic             wdReset
);

  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

  logic [7:0]       lfsr;
  logic [1:0]       streak;
  logic [ERR_W-1:0] errInc;
  logic [7:0]       expected;

  assign expected  = rotl8(lfsr ^ stepKey(stepIdx), stepIdx);
  assign respMatch = (respData == expected);
  assign errInc    = (errCount == ERR_MAX) ? errCount : errCount + 1'b1;
  assign challenge = lfsr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr     <= ZERO_SEED_FILL;
      stepIdx  <= '0;
      errCount <= '0;
      streak   <= '0;
      wdReset  <= 1'b0;
    end else if (ctrl.clr) begin
      stepIdx  <= '0;
      errCount <= '0;
      streak   <= '0;
      wdReset  <= 1'b0;
    end else begin
      if (ctrl.load) begin
        lfsr     <= (seedIn == 8'h00) ? ZERO_SEED_FILL : seedIn;
        stepIdx  <= '0;
        errCount <= '0;
        streak   <= '0;
      end
      if (ctrl.advance) begin
        lfsr    <= lfsrStep(lfsr);
        stepIdx <= stepIdx + 2'd1;
      end
      if (ctrl.bad) begin
        streak   <= '0;
        errCount <= errInc;
        if (errInc >= errLimit) wdReset <= 1'b1;
      end
      if (ctrl.good) begin
        if (streak == 2'd3) begin
          streak <= '0;
          if (errCount != '0) errCount <= errCount - 1'b1;
        end else begin
          streak <= streak + 2'd1;
        end
      end
    end
  end

  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != 8'h00);

  // R9
  trip_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wdReset && !ctrl.clr) |=> wdReset);

  // R8
  err_delta_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.clr && !ctrl.load) |=> (errCount == $past(errCount)) ||
      (errCount == $past(errCount) + 1'b1) || (errCount == $past(errCount) - 1'b1));

  // R2
  load_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.clr) |=> (stepIdx == 2'd0));

endmodule

// File: rtl/qa_wd_control.sv
module qa_wd_control
  import qa_wd_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             respStrobe,
  input  logic             respMatch,
  input  logic             wdReset,
  input  logic [WIN_W-1:0] winOpen,
  input  logic [WIN_W-1:0] winClose,
  output qaCtrl_t          ctrl,
  output logic             challengeValid
);

  typedef enum logic [1:0] {IDLE, RUN, HALT} qaState_t;

  qaState_t         state;
  logic [WIN_W-1:0] timer;
  logic             live;
  logic             inWindow;
  logic             expire;

  assign live           = (state == RUN) && !wdReset;
  assign challengeValid = live;
  assign inWindow       = (timer >= winOpen) && (timer <= winClose);
  assign expire         = timer >= winClose;

  always_comb begin
    ctrl         = '0;
    ctrl.clr     = !enable;
    ctrl.load    = enable && (state == IDLE);
    if (enable && live) begin
      if (respStrobe) begin
        ctrl.advance = 1'b1;
        ctrl.good    = respMatch && inWindow;
        ctrl.bad     = !(respMatch && inWindow);
      end else if (expire) begin
        ctrl.advance = 1'b1;
        ctrl.bad     = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= IDLE;
      timer <= '0;
    end else if (!enable) begin
      state <= IDLE;
      timer <= '0;
    end else begin
      case (state)
        IDLE: begin
          state <= RUN;
          timer <= '0;
        end
        RUN: begin
          if (wdReset)           state <= HALT;
          else if (ctrl.advance) timer <= '0;
          else                   timer <= timer + 1'b1;
        end
        default: state <= HALT;
      endcase
    end
  end

  // R5
  verdict_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.advance |-> $onehot({ctrl.good, ctrl.bad}));

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == HALT) |-> !ctrl.advance);

endmodule

// File: rtl/qa_watchdog.sv
module qa_watchdog
  import qa_wd_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [7:0]       seedIn,
  input  logic [WIN_W-1:0] winOpen,
  input  logic [WIN_W-1:0] winClose,
  input  logic [ERR_W-1:0] errLimit,
  input  logic [7:0]       respData,
  input  logic             respStrobe,
  output logic [7:0]       challenge,
  output logic             challengeValid,
  output logic [1:0]       stepIdx,
  output logic [ERR_W-1:0] errCount,
  output logic             wdReset
);

  qaCtrl_t ctrl;
  logic    respMatch;

  qa_wd_control #(.WIN_W(WIN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .respStrobe(respStrobe),
    .respMatch(respMatch), .wdReset(wdReset), .winOpen(winOpen),
    .winClose(winClose), .ctrl(ctrl), .challengeValid(challengeValid)
  );

  qa_wd_datapath #(.ERR_W(ERR_W)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .seedIn(seedIn), .errLimit(errLimit),
    .respData(respData), .respMatch(respMatch), .challenge(challenge),
    .stepIdx(stepIdx), .errCount(errCount), .wdReset(wdReset)
  );

  // R9
  trip_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> !challengeValid);

  // R10
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (errCount == '0) && !wdReset && !challengeValid);

endmodule

// File: tb/sim_qa_watchdog.sv
module sim_qa_watchdog;
  import qa_wd_pkg::*;

  localparam int WIN_W = 8;
  localparam int ERR_W = 4;
  localparam int WO = 2;
  localparam int WC = 5;
  localparam int LIM = 4;
  localparam int NV = 14;
  // {skip, wrong, delay[7:0]}
  localparam logic [9:0] VEC [NV] = '{
    {2'b00, 8'd3}, {2'b00, 8'd2}, {2'b00, 8'd5}, {2'b00, 8'd4},
    {2'b00, 8'd1}, {2'b01, 8'd3},
    {2'b00, 8'd3}, {2'b00, 8'd2}, {2'b00, 8'd4}, {2'b00, 8'd3},
    {2'b10, 8'd0}, {2'b00, 8'd5}, {2'b01, 8'd2}, {2'b00, 8'd0}
  };

  logic clk = 0, rstN = 0, enable = 0, respStrobe = 0;
  logic [7:0] seedIn = 0, respData = 0;
  logic [WIN_W-1:0] winOpen = WO[WIN_W-1:0], winClose = WC[WIN_W-1:0];
  logic [ERR_W-1:0] errLimit = LIM[ERR_W-1:0];
  logic [7:0] challenge;
  logic challengeValid, wdReset;
  logic [1:0] stepIdx;
  logic [ERR_W-1:0] errCount;

  int nRun = 0, nFail = 0;
  logic [7:0] mCh;
  int mStep = 0, mErr = 0, mStreak = 0;
  bit mTrip = 0;

  always #5 clk = ~clk;

  qa_watchdog #(.WIN_W(WIN_W), .ERR_W(ERR_W)) u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .seedIn(seedIn),
    .winOpen(winOpen), .winClose(winClose), .errLimit(errLimit),
    .respData(respData), .respStrobe(respStrobe), .challenge(challenge),
    .challengeValid(challengeValid), .stepIdx(stepIdx), .errCount(errCount),
    .wdReset(wdReset)
  );

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] answerFor(input logic [7:0] c, input int k);
    logic [7:0] x;
    x = c ^ ((k == 0) ? 8'h3C : (k == 1) ? 8'h5A : (k == 2) ? 8'h96 : 8'hE1);
    return (k == 0) ? x : 8'((x << k) | (x >> (8 - k)));
  endfunction

  task automatic answer(input int delay, input bit wrong, input bit skip);
    if (skip) begin
      repeat (WC + 1) @(negedge clk);
    end else begin
      repeat (delay) @(negedge clk);
      respData = answerFor(challenge, stepIdx) ^ (wrong ? 8'h01 : 8'h00);
      respStrobe = 1;
      @(negedge clk);
      respStrobe = 0;
    end
  endtask

  task automatic modelStep(input bit isBad);
    if (mTrip) return;
    if (isBad) begin
      mStreak = 0;
      if (mErr < 15) mErr++;
      if (mErr >= LIM) mTrip = 1;
    end else if (mStreak == 3) begin
      mStreak = 0;
      if (mErr > 0) mErr--;
    end else mStreak++;
    mCh = {mCh[6:0], mCh[7] ^ mCh[5] ^ mCh[4] ^ mCh[3]};
    mStep = (mStep + 1) % 4;
  endtask

  initial begin
    #2_000_000;
    nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid", challengeValid, 0);
    check("R1 wdReset", wdReset, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check("R1 errCount", errCount, 0);
    check("R1 stepIdx", stepIdx, 0);
    check("R1 valid idle", challengeValid, 0);

    seedIn = 8'h5C; enable = 1;
    @(negedge clk);
    mCh = 8'h5C;
    check("R2 seed load", challenge, 8'h5C);
    check("R2 valid", challengeValid, 1);

    for (int i = 0; i < NV; i++) begin
      bit sk, wr; int dl;
      sk = VEC[i][9]; wr = VEC[i][8]; dl = int'(VEC[i][7:0]);
      check("R3 challenge", challenge, mCh);
      check("R4 stepIdx", stepIdx, mStep);
      answer(dl, wr, sk);
      // R5 early, R6 miss, R7 wrong, R8 run of four
      modelStep(sk || wr || dl < WO);
      check("R5 R6 R7 R8 errCount", errCount, mErr);
      check("R9 wdReset", wdReset, mTrip);
      if (!mTrip) check("R3 next challenge", challenge, mCh);
    end

    check("R9 valid low", challengeValid, 0);
    answer(3, 0, 0);
    @(negedge clk);
    check("R9 ignored errCount", errCount, LIM);
    check("R9 still set", wdReset, 1);
    check("R9 still silent", challengeValid, 0);

    enable = 0;
    @(negedge clk);
    check("R10 errCount", errCount, 0);
    check("R10 wdReset", wdReset, 0);
    check("R10 valid", challengeValid, 0);
    check("R10 stepIdx", stepIdx, 0);

    seedIn = 8'h00; enable = 1;
    @(negedge clk);
    check("R2 zero seed", challenge, 8'hA5);
    check("R2 revalid", challengeValid, 1);
    mCh = 8'hA5; mStep = 0; mErr = 0; mStreak = 0; mTrip = 0;
    answer(WO, 0, 0);
    modelStep(0);
    check("R4 answer after reload", errCount, 0);
    check("R3 step after reload", challenge, mCh);
    check("R3 stepIdx after reload", stepIdx, 1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule